// File: doc/BRIEF.md
# Video Frame Timing Generator

This block produces the line and frame timing for an 8-bit parallel image output. It divides the master clock into output pixel periods. It counts periods within a line and lines within a frame, and from those counts it drives a frame sync, a line pin and the column and row read addresses of a raw Bayer array. The line pin carries either a line-valid window or a programmable sync pulse.

A frame has three parts in order. First come a fixed number of sync lines. Then come a programmable number of leading dummy lines and the active rows. Last come a programmable number of trailing dummy lines. Inside the active rows, a rectangular window sets where the line-valid output is high. Each window bound is a 10-bit value. Its high eight bits come from a register of its own, and its two low bits come from one shared byte.

Mirror reverses the column read order and flip reverses the row read order. Both reversed orders start one pixel further out, so that the colour phase of the Bayer pattern does not change. Polarity inversion is available for each output, and the sync levels can be forced.

Top module: `vid_frame_timer`

## Requirements
- R1: One output period lasts DIV master clocks. `pix_ce` is high in the last clock of each period. A line lasts LINE_PIX periods.
- R2: A frame lasts SYNC_LINES + `pre_lines` + ROWS + `post_lines` lines. The frame sync is active during the first SYNC_LINES lines. It is active low by default, and `vs_pol_high`=1 makes it active high.
- R3: The window bounds are built as follows: column start = {`hstart_hi`, `win_lsb[1:0]`}, column stop = {`hstop_hi`, `win_lsb[3:2]`}, row start = {`vstart_hi`, `win_lsb[5:4]`}, row stop = {`vstop_hi`, `win_lsb[7:6]`}.
- R4: Line-valid is active on an active row whose index r meets row start <= r < row stop, at a period count h that meets column start <= h < column stop. It is active high unless `href_pol_low`=1.
- R5: If a stop value is less than or equal to its start value, line-valid never becomes active.
- R6: With `href_lead`=1 and column start > 0, line-valid is also active at h = column start - 1 on every row that qualifies.
- R7: For h < COLS, `col_addr` is h, or COLS - h when `mirror`=1 (so the order is 652..1 by default). For other h it is 0.
- R8: On active row r, `row_addr` is r, or ROWS - r when `flip`=1. On all other lines it is 0.
- R9: The sync pulse is high on every line for `hs_rise` <= h < `hs_fall`. `line_sel_hs`=1 routes it to `line_o` in place of line-valid, and `hs_pol_low`=1 inverts it.
- R10: `force_sync`=2'b10 drives `line_o` and `vsync_o` both low. 2'b11 drives both high. 2'b0x leaves them normal.
- R11: During reset the period, line and frame counts are zero. So `pix_ce`=0, `vsync_o` is at its active level, `line_o`=0, and both addresses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_lsb | input | 8 | Low two bits of the four window bounds |
| hstart_hi | input | 8 | Column start, high bits |
| hstop_hi | input | 8 | Column stop, high bits |
| vstart_hi | input | 8 | Row start, high bits |
| vstop_hi | input | 8 | Row stop, high bits |
| pre_lines | input | 16 | Dummy lines before the active rows |
| post_lines | input | 16 | Dummy lines after the active rows |
| hs_rise | input | 12 | Sync pulse rising position |
| hs_fall | input | 12 | Sync pulse falling position |
| href_pol_low | input | 1 | Invert line-valid |
| vs_pol_high | input | 1 | Frame sync active high |
| hs_pol_low | input | 1 | Invert sync pulse |
| line_sel_hs | input | 1 | Put the sync pulse on line_o |
| force_sync | input | 2 | Sync level override |
| href_lead | input | 1 | Line-valid one period early |
| mirror | input | 1 | Reverse column order |
| flip | input | 1 | Reverse row order |
| pix_ce | output | 1 | Period strobe |
| vsync_o | output | 1 | Frame sync |
| line_o | output | 1 | Line-valid or sync pulse |
| col_addr | output | $clog2(COLS+1) | Column read address |
| row_addr | output | $clog2(ROWS+1) | Row read address |

## Verification
A wrong period or line count shows up within one period on `col_addr` and `pix_ce`. It shows up at the next line boundary on `row_addr`, and at the next frame boundary on the frame sync. A wrong window decode or colour-order offset shows up as a shifted line-valid edge or an address off by one during the first active row. For this reason, the outputs are compared with a behavioural model on every clock. The number of active line periods per frame is also checked against an arithmetic count.

// File: rtl/vft_pkg.sv
// Shared types and field widths for the frame timing generator.
package vft_pkg;
    typedef enum logic [1:0] {LN_SYNC, LN_LEAD, LN_ACTIVE, LN_TRAIL} line_kind_e;
    localparam int WIN_W  = 10;  // window bound width (8 high + 2 low)
    localparam int EDGE_W = 12;  // sync pulse edge position width
    localparam int DUM_W  = 16;  // dummy line count width
endpackage

// File: rtl/vft_line_counter.sv
// Period prescaler and in-line period counter.
// Assumes LINE_PIX >= 2. The count advances only on tick.
module vft_line_counter #(
    parameter  int LINE_PIX = 784,
    parameter  int DIV      = 2,
    localparam int HW       = $clog2(LINE_PIX)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          tick,
    output logic [HW-1:0] hcnt,
    output logic          line_end
);
    localparam logic [HW-1:0] H_LAST = HW'(LINE_PIX - 1);

    generate
        if (DIV > 1) begin : g_pre
            localparam int PW = $clog2(DIV);
            logic [PW-1:0] pre_q;
            // divide the master clock into output periods
            always_ff @(posedge clk) begin
                if (!rst_n)                      pre_q <= '0;
                else if (pre_q == PW'(DIV - 1)) pre_q <= '0;
                else                             pre_q <= pre_q + 1'b1;
            end
            assign tick = (pre_q == PW'(DIV - 1));
        end else begin : g_nopre
            assign tick = 1'b1;
        end
    endgenerate

    // count periods within the line
    always_ff @(posedge clk) begin
        if (!rst_n)           hcnt <= '0;
        else if (tick)        hcnt <= (hcnt == H_LAST) ? '0 : hcnt + 1'b1;
    end

    assign line_end = tick && (hcnt == H_LAST);

    p_hcnt_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> (hcnt == '0));
    p_hcnt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(hcnt));
endmodule

// File: rtl/vft_frame_counter.sv
// Line counter within the frame, and decode of the line kind and active row index.
// Assumes SYNC_LINES >= 1. The dummy counts are read live.
module vft_frame_counter
    import vft_pkg::*;
#(
    parameter  int ROWS       = 492,
    parameter  int SYNC_LINES = 3,
    localparam int VW         = DUM_W + 2,
    localparam int RAW        = $clog2(ROWS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_end,
    input  logic [DUM_W-1:0] pre_lines,
    input  logic [DUM_W-1:0] post_lines,
    output line_kind_e       kind,
    output logic [RAW-1:0]   row_idx
);
    logic [VW-1:0] vcnt, lead_end, act_end, last_line;

    assign lead_end  = VW'(SYNC_LINES) + VW'(pre_lines);
    assign act_end   = lead_end + VW'(ROWS);
    assign last_line = act_end + VW'(post_lines) - 1'b1;

    // count lines within the frame
    always_ff @(posedge clk) begin
        if (!rst_n)        vcnt <= '0;
        else if (line_end) vcnt <= (vcnt >= last_line) ? '0 : vcnt + 1'b1;
    end

    // classify the current line and derive the active row index
    always_comb begin
        row_idx = '0;
        if (vcnt < VW'(SYNC_LINES))  kind = LN_SYNC;
        else if (vcnt < lead_end)    kind = LN_LEAD;
        else if (vcnt < act_end) begin
            kind    = LN_ACTIVE;
            row_idx = RAW'(vcnt - lead_end);
        end
        else                         kind = LN_TRAIL;
    end

    p_frame_opens_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vcnt == '0) |-> (kind == LN_SYNC));
    p_row_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && kind == LN_ACTIVE && row_idx != RAW'(ROWS - 1))
        |=> (kind == LN_ACTIVE && row_idx == $past(row_idx) + 1'b1));
endmodule

// File: rtl/vft_addr_gen.sv
// Column and row read addresses. Mirror and flip start one pixel out
// so that the Bayer colour phase is kept.
module vft_addr_gen
    import vft_pkg::*;
#(
    parameter  int COLS = 652,
    parameter  int ROWS = 492,
    parameter  int HW   = 10,
    localparam int CAW  = $clog2(COLS + 1),
    localparam int RAW  = $clog2(ROWS + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [HW-1:0]  hcnt,
    input  line_kind_e     kind,
    input  logic [RAW-1:0] row_idx,
    input  logic           mirror,
    input  logic           flip,
    output logic [CAW-1:0] col_addr,
    output logic [RAW-1:0] row_addr
);
    logic in_cols;
    assign in_cols = (32'(hcnt) < COLS);

    // column order, forward or reversed
    always_comb begin
        if (!in_cols)     col_addr = '0;
        else if (mirror)  col_addr = CAW'(COLS) - CAW'(hcnt);
        else              col_addr = CAW'(hcnt);
    end

    // row order, forward or reversed
    always_comb begin
        if (kind != LN_ACTIVE) row_addr = '0;
        else if (flip)         row_addr = RAW'(ROWS) - row_idx;
        else                   row_addr = row_idx;
    end

    p_col_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        col_addr <= CAW'(COLS));
    p_mirror_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mirror && in_cols) |-> (col_addr != '0));
    p_row_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        row_addr <= RAW'(ROWS));
endmodule

// File: rtl/vft_sync_out.sv
// Line-valid window, sync pulse, polarity and force logic.
// Assumes the bounds are stable while the block counts.
module vft_sync_out
    import vft_pkg::*;
#(
    parameter int HW  = 10,
    parameter int RAW = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HW-1:0]     hcnt,
    input  line_kind_e        kind,
    input  logic [RAW-1:0]    row_idx,
    input  logic [WIN_W-1:0]  h_start,
    input  logic [WIN_W-1:0]  h_stop,
    input  logic [WIN_W-1:0]  v_start,
    input  logic [WIN_W-1:0]  v_stop,
    input  logic [EDGE_W-1:0] hs_rise,
    input  logic [EDGE_W-1:0] hs_fall,
    input  logic              href_pol_low,
    input  logic              vs_pol_high,
    input  logic              hs_pol_low,
    input  logic              line_sel_hs,
    input  logic [1:0]        force_sync,
    input  logic              href_lead,
    output logic              line_o,
    output logic              vsync_o
);
    logic [15:0] h16, r16;
    logic        row_ok, col_ok, lead_ok, href_act, hs_act, line_lvl, vs_lvl;

    assign h16 = 16'(hcnt);
    assign r16 = 16'(row_idx);

    // window qualification on rows and columns
    always_comb begin
        row_ok  = (kind == LN_ACTIVE) && (v_start < v_stop)
                  && (r16 >= 16'(v_start)) && (r16 < 16'(v_stop));
        col_ok  = (h_start < h_stop) && (h16 >= 16'(h_start)) && (h16 < 16'(h_stop));
        lead_ok = href_lead && (h_start < h_stop) && (h16 + 16'd1 == 16'(h_start));
        href_act = row_ok && (col_ok || lead_ok);
        hs_act   = (h16 >= 16'(hs_rise)) && (h16 < 16'(hs_fall));
    end

    // polarity selection, then the force override
    always_comb begin
        line_lvl = line_sel_hs ? (hs_act ^ hs_pol_low) : (href_act ^ href_pol_low);
        vs_lvl   = (kind == LN_SYNC) ~^ vs_pol_high;
        if (force_sync[1]) begin
            line_o  = force_sync[0];
            vsync_o = force_sync[0];
        end else begin
            line_o  = line_lvl;
            vsync_o = vs_lvl;
        end
    end

    p_href_on_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        href_act |-> (kind == LN_ACTIVE));
    p_force_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        force_sync[1] |-> (line_o == force_sync[0] && vsync_o == force_sync[0]));
endmodule

// File: rtl/vid_frame_timer.sv
// Top level of the frame timing generator. It builds the window bounds
// from the split registers and connects the counters, the address
// generator and the sync outputs.
module vid_frame_timer
    import vft_pkg::*;
#(
    parameter  int LINE_PIX   = 784,
    parameter  int COLS       = 652,
    parameter  int ROWS       = 492,
    parameter  int SYNC_LINES = 3,
    parameter  int DIV        = 2,
    localparam int CAW        = $clog2(COLS + 1),
    localparam int RAW        = $clog2(ROWS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        win_lsb,
    input  logic [7:0]        hstart_hi,
    input  logic [7:0]        hstop_hi,
    input  logic [7:0]        vstart_hi,
    input  logic [7:0]        vstop_hi,
    input  logic [15:0]       pre_lines,
    input  logic [15:0]       post_lines,
    input  logic [11:0]       hs_rise,
    input  logic [11:0]       hs_fall,
    input  logic              href_pol_low,
    input  logic              vs_pol_high,
    input  logic              hs_pol_low,
    input  logic              line_sel_hs,
    input  logic [1:0]        force_sync,
    input  logic              href_lead,
    input  logic              mirror,
    input  logic              flip,
    output logic              pix_ce,
    output logic              vsync_o,
    output logic              line_o,
    output logic [CAW-1:0]    col_addr,
    output logic [RAW-1:0]    row_addr
);
    localparam int HW = $clog2(LINE_PIX);

    logic [HW-1:0]    hcnt;
    logic             line_end;
    line_kind_e       kind;
    logic [RAW-1:0]   row_idx;
    logic [WIN_W-1:0] h_start, h_stop, v_start, v_stop;

    // join the high and low parts of each window bound
    assign h_start = {hstart_hi, win_lsb[1:0]};
    assign h_stop  = {hstop_hi,  win_lsb[3:2]};
    assign v_start = {vstart_hi, win_lsb[5:4]};
    assign v_stop  = {vstop_hi,  win_lsb[7:6]};

    vft_line_counter #(.LINE_PIX(LINE_PIX), .DIV(DIV)) u_line (
        .clk(clk), .rst_n(rst_n), .tick(pix_ce), .hcnt(hcnt), .line_end(line_end));

    vft_frame_counter #(.ROWS(ROWS), .SYNC_LINES(SYNC_LINES)) u_frame (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .pre_lines(pre_lines),
        .post_lines(post_lines), .kind(kind), .row_idx(row_idx));

    vft_addr_gen #(.COLS(COLS), .ROWS(ROWS), .HW(HW)) u_addr (
        .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .kind(kind), .row_idx(row_idx),
        .mirror(mirror), .flip(flip), .col_addr(col_addr), .row_addr(row_addr));

    vft_sync_out #(.HW(HW), .RAW(RAW)) u_sync (
        .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .kind(kind), .row_idx(row_idx),
        .h_start(h_start), .h_stop(h_stop), .v_start(v_start), .v_stop(v_stop),
        .hs_rise(hs_rise), .hs_fall(hs_fall), .href_pol_low(href_pol_low),
        .vs_pol_high(vs_pol_high), .hs_pol_low(hs_pol_low), .line_sel_hs(line_sel_hs),
        .force_sync(force_sync), .href_lead(href_lead), .line_o(line_o), .vsync_o(vsync_o));
endmodule

// File: tb/vid_frame_timer_bench.sv
// Bench: a behavioural reference model compared with the outputs on every clock,
// plus arithmetic counts of active line periods for each frame.
module vid_frame_timer_bench;
    localparam int LP = 24, NC = 16, NR = 6, SL = 2, DV = 2;
    localparam int CAW = $clog2(NC + 1), RAW = $clog2(NR + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] win_lsb, hstart_hi, hstop_hi, vstart_hi, vstop_hi;
    logic [15:0] pre_lines, post_lines;
    logic [11:0] hs_rise, hs_fall;
    logic href_pol_low, vs_pol_high, hs_pol_low, line_sel_hs, href_lead, mirror, flip;
    logic [1:0] force_sync;
    logic pix_ce, vsync_o, line_o;
    logic [CAW-1:0] col_addr;
    logic [RAW-1:0] row_addr;

    int checks = 0, errors = 0, act_cnt = 0;
    int m_div = 0, m_h = 0, m_v = 0;
    bit seen = 0, done = 0;

    always #4 clk = ~clk;

    vid_frame_timer #(.LINE_PIX(LP), .COLS(NC), .ROWS(NR), .SYNC_LINES(SL), .DIV(DV))
    u_vid_frame_timer (
        .clk(clk), .rst_n(rst_n), .win_lsb(win_lsb), .hstart_hi(hstart_hi),
        .hstop_hi(hstop_hi), .vstart_hi(vstart_hi), .vstop_hi(vstop_hi),
        .pre_lines(pre_lines), .post_lines(post_lines), .hs_rise(hs_rise),
        .hs_fall(hs_fall), .href_pol_low(href_pol_low), .vs_pol_high(vs_pol_high),
        .hs_pol_low(hs_pol_low), .line_sel_hs(line_sel_hs), .force_sync(force_sync),
        .href_lead(href_lead), .mirror(mirror), .flip(flip), .pix_ce(pix_ce),
        .vsync_o(vsync_o), .line_o(line_o), .col_addr(col_addr), .row_addr(row_addr));

    function automatic int total_lines();
        return SL + int'(pre_lines) + NR + int'(post_lines);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model state
    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 0; m_h = 0; m_v = 0;
        end else if (m_div == DV - 1) begin
            m_div = 0;
            if (m_h == LP - 1) begin
                m_h = 0;
                m_v = (m_v >= total_lines() - 1) ? 0 : m_v + 1;
            end else m_h++;
        end else m_div++;
        seen = 1;
    end

    // compare away from the edge
    always @(posedge clk) begin
        #3;
        if (seen && !done) begin
            int hs, he, vs, ve, r, e_col, e_row;
            bit act, sync, href, hsy, e_line, e_vs, lvl;
            hs = {hstart_hi, win_lsb[1:0]}; he = {hstop_hi, win_lsb[3:2]};
            vs = {vstart_hi, win_lsb[5:4]}; ve = {vstop_hi, win_lsb[7:6]};
            sync = (m_v < SL);
            act  = (m_v >= SL + int'(pre_lines)) && (m_v < SL + int'(pre_lines) + NR);
            r    = m_v - SL - int'(pre_lines);
            href = act && hs < he && vs < ve && r >= vs && r < ve &&
                   ((m_h >= hs && m_h < he) || (href_lead && hs > 0 && m_h == hs - 1));
            hsy  = (m_h >= int'(hs_rise)) && (m_h < int'(hs_fall));
            e_line = line_sel_hs ? (hsy ^ hs_pol_low) : (href ^ href_pol_low);
            e_vs   = vs_pol_high ? sync : !sync;
            if (force_sync[1]) begin e_line = force_sync[0]; e_vs = force_sync[0]; end
            e_col = (m_h < NC) ? (mirror ? NC - m_h : m_h) : 0;
            e_row = act ? (flip ? NR - r : r) : 0;
            chk("R1 pix_ce", int'(pix_ce), int'(m_div == DV - 1));
            chk("R2 vsync_o", int'(vsync_o), int'(e_vs));
            chk("R4 line_o", int'(line_o), int'(e_line));
            chk("R7 col_addr", int'(col_addr), e_col);
            chk("R8 row_addr", int'(row_addr), e_row);
            if (rst_n && pix_ce && !force_sync[1]) begin
                lvl = line_sel_hs ? (line_o ^ hs_pol_low) : (line_o ^ href_pol_low);
                if (lvl) act_cnt++;
            end
        end
    end

    task automatic set_win(input int hs, input int he, input int vs, input int ve);
        hstart_hi = 8'(hs >> 2); hstop_hi = 8'(he >> 2);
        vstart_hi = 8'(vs >> 2); vstop_hi = 8'(ve >> 2);
        win_lsb = {2'(ve), 2'(vs), 2'(he), 2'(hs)};
    endtask

    task automatic defaults();
        set_win(2, 10, 1, 5);
        pre_lines = 16'd1; post_lines = 16'd2; hs_rise = 12'd3; hs_fall = 12'd7;
        href_pol_low = 0; vs_pol_high = 0; hs_pol_low = 0; line_sel_hs = 0;
        force_sync = 2'b00; href_lead = 0; mirror = 0; flip = 0;
    endtask

    // reset, then run a whole number of frames and compare the active count
    task automatic run(input int frames, input int exp_per_frame, input string tag);
        rst_n = 0;
        repeat (2) @(negedge clk);
        act_cnt = 0;
        rst_n = 1;
        repeat (frames * total_lines() * LP * DV) @(posedge clk);
        @(negedge clk);
        chk(tag, act_cnt, frames * exp_per_frame);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        defaults();
        repeat (2) @(negedge clk);
        // R11: reset state
        chk("R11 pix_ce", int'(pix_ce), 0);
        chk("R11 vsync_o", int'(vsync_o), 0);
        chk("R11 line_o", int'(line_o), 0);
        chk("R11 col_addr", int'(col_addr), 0);
        chk("R11 row_addr", int'(row_addr), 0);
        // R3/R4: 8 columns x 4 rows per frame
        run(2, 32, "R3 window count");
        // R6 with mirror/flip and inverted polarities, no dummies
        href_lead = 1; mirror = 1; flip = 1; href_pol_low = 1; vs_pol_high = 1;
        pre_lines = 0; post_lines = 0;
        run(2, 36, "R6 lead count");
        // R5: empty windows
        defaults(); set_win(2, 2, 1, 5);
        run(1, 0, "R5 h stop==start");
        set_win(2, 10, 5, 3);
        run(1, 0, "R5 v stop<start");
        // R9: sync pulse on the line pin, 4 periods on all 11 lines
        defaults(); line_sel_hs = 1; hs_pol_low = 1; vs_pol_high = 1;
        run(1, 44, "R9 hsync count");
        // R10: forced levels
        defaults(); force_sync = 2'b10;
        run(1, 0, "R10 force low");
        chk("R10 line low", int'(line_o), 0);
        chk("R10 vsync low", int'(vsync_o), 0);
        force_sync = 2'b11;
        run(1, 0, "R10 force high");
        chk("R10 line high", int'(line_o), 1);
        chk("R10 vsync high", int'(vsync_o), 1);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule